// File: doc/BRIEF.md
# Multi-lane stencil reuse buffer

This block is the on-chip line-buffer memory for a 3x3 square stencil engine that works on `LANES` adjacent grid points per clock. A row-major stream of grid elements enters `LANES` at a time. Each input beat carries one aligned group of columns. Each element is fetched from outside exactly once. Every cycle the block presents the complete 3x3 neighbourhood for `LANES` adjacent centre positions, so that `LANES` kernels placed downstream can each produce one result per clock. The stencil arithmetic and the choice between computed and halo results are left to the logic that consumes the windows.

Storage is split by column index modulo `LANES` into reuse chains, one per lane. Each chain is a cascade of tap registers, which can all be read in parallel, and gap delay lines, which hold the elements that are needed only on later beats. All chains advance together on every accepted beat. The two chains holding the columns that flank the centre group need two taps per row. Every other chain needs one tap per row. Each chain therefore holds only as many entries as it needs, and for four lanes the total storage is two full rows plus six elements. `WIDTH` must be a multiple of `LANES`, with `LANES >= 2`, `WIDTH/LANES >= 2` and `HEIGHT >= 3`.

A window-valid flag reports when enough rows of the current frame have arrived for the presented windows to be filled from that frame.

Top module: `stencil_reuse_buffer`

## Requirements
- R1: A beat is accepted on a rising clock edge while `in_valid` is high. Lane l of the k-th accepted beat (k = 0, 1, ...) carries stream element k*LANES + l, and that element enters chain l. Window (m=0, row 2, col 2) then equals the lane-0 element of that beat, and window (m=LANES-1, row 2, col 2) equals its lane LANES-1 element.
- R2: Let X be the stream index of the lane-0 element of the newest accepted beat, and B = WIDTH/LANES. Window m (0..LANES-1) is centred on stream index X - WIDTH - 1 + m. Its entry [r][c] (r, c in 0..2, with row 0 the oldest row and col 0 the leftmost column) equals stream element X - WIDTH - 1 + m + (r-1)*WIDTH + (c-1). All window outputs change one clock after the accepting edge.
- R3: Chains LANES-2 and LANES-1 are the edge chains. Each exposes six taps, with ages 0, 1, B, B+1, 2B and 2B+1 beats. Every other chain exposes three taps, with ages 0, B and 2B. Window entries whose column offset m+c-2 is negative come from the age-(1 + row lag) taps of the edge chains, so an edge chain holds 2B+2 entries and any other chain holds 2B+1.
- R4: While `in_valid` is low, no chain shifts, and all window entries and `win_valid` keep their values.
- R5: After synchronous reset, and until the first beat is accepted, every window entry is zero and `win_valid` is low. Window entries that refer to stream positions before the first accepted element read zero.
- R6: A frame is HEIGHT*B beats. `win_valid` is high exactly when the number of beats accepted in the current frame is at least 2B+1. The first beat of the next frame restarts that count at one, so `win_valid` falls on that beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept the beat on `in_lane` at this edge |
| in_lane | input | LANES*DATA_W | One element per lane; lane l carries column offset l of the beat |
| win | output | LANES*9*DATA_W | Windows indexed [m][row][col], each entry DATA_W bits |
| win_valid | output | 1 | Windows are filled from the current frame |

## Verification
Assertions check on every cycle that the newest elements land in the bottom-right corners of the windows and that the entries drawn from the previous beat show lane LANES-2 from one beat earlier. They also check that a stall freezes every output, that the frame counter stays within range, and that `win_valid` rises only on an accept and falls only on the first beat of a frame. The exact arithmetic position of every one of the nine entries in every window is shown only by the bench's sweep. This includes the entries that come out of the gap delay lines two rows back, the zero prehistory after reset, and the valid pattern across several frames with irregular stalls.

// File: rtl/srb_pkg.sv
package srb_pkg;

    typedef enum logic {
        CHAIN_MID  = 1'b0,
        CHAIN_EDGE = 1'b1
    } chain_kind_e;

    localparam int WIN_DIM = 3;

    // the two highest lanes flank the centre group and need a second tap per row
    function automatic chain_kind_e kind_of(input int lane, input int lanes);
        return (lane >= lanes - 2) ? CHAIN_EDGE : CHAIN_MID;
    endfunction

    function automatic int taps_per_row(input chain_kind_e kind);
        return (kind == CHAIN_EDGE) ? 2 : 1;
    endfunction

    // beats between the last tap of one row and the first tap of the next
    function automatic int gap_depth(input chain_kind_e kind, input int beats);
        return beats - taps_per_row(kind);
    endfunction

endpackage

// File: rtl/rb_gap_fifo.sv
module rb_gap_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    logic [DEPTH-1:0][DATA_W-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else if (shift_en) begin
            stage_q[0] <= din;
            for (int i = 1; i < DEPTH; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign dout = stage_q[DEPTH-1];

endmodule

// File: rtl/rb_chain.sv
module rb_chain
    import srb_pkg::*;
#(
    parameter int          DATA_W = 8,
    parameter int          BEATS  = 4,
    parameter chain_kind_e KIND   = CHAIN_MID,
    localparam int         PER    = taps_per_row(KIND),
    localparam int         TAPS   = WIN_DIM * PER
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       shift_en,
    input  logic [DATA_W-1:0]          din,
    output logic [TAPS-1:0][DATA_W-1:0] taps
);

    localparam int GAP = gap_depth(KIND, BEATS);

    // entry point of each row segment
    logic [DATA_W-1:0] row_in [WIN_DIM];

    assign row_in[0] = din;

    // tap k*PER+i has age k*BEATS+i beats
    always_ff @(posedge clk) begin
        if (rst) begin
            taps <= '0;
        end else if (shift_en) begin
            for (int k = 0; k < WIN_DIM; k++) begin
                taps[k*PER] <= row_in[k];
                for (int i = 1; i < PER; i++) begin
                    taps[k*PER+i] <= taps[k*PER+i-1];
                end
            end
        end
    end

    for (genvar k = 0; k < WIN_DIM - 1; k++) begin : g_gap
        if (GAP > 0) begin : g_fifo
            rb_gap_fifo #(
                .DATA_W(DATA_W),
                .DEPTH (GAP)
            ) gap_i (
                .clk     (clk),
                .rst     (rst),
                .shift_en(shift_en),
                .din     (taps[k*PER+PER-1]),
                .dout    (row_in[k+1])
            );
        end else begin : g_direct
            assign row_in[k+1] = taps[k*PER+PER-1];
        end
    end

endmodule

// File: rtl/rb_fill_tracker.sv
module rb_fill_tracker #(
    parameter int FRAME_BEATS = 24,
    parameter int FILL_BEATS  = 9
) (
    input  logic clk,
    input  logic rst,
    input  logic accept,
    output logic win_valid
);

    localparam int            CW         = $clog2(FRAME_BEATS + 1);
    localparam logic [CW-1:0] FRAME_LAST = CW'(FRAME_BEATS);
    localparam logic [CW-1:0] FILL_MIN   = CW'(FILL_BEATS);
    localparam logic [CW-1:0] ONE        = CW'(1);

    logic [CW-1:0] beat_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_cnt <= '0;
        end else if (accept) begin
            beat_cnt <= (beat_cnt == FRAME_LAST) ? ONE : beat_cnt + ONE;
        end
    end

    assign win_valid = (beat_cnt >= FILL_MIN);

    // R6
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        beat_cnt <= FRAME_LAST);

    // R6
    valid_rise_on_accept_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(win_valid) |-> $past(accept));

    // R6
    valid_fall_at_frame_start_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(win_valid) |-> ($past(accept) && beat_cnt == ONE));

endmodule

// File: rtl/stencil_reuse_buffer.sv
module stencil_reuse_buffer
    import srb_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int WIDTH  = 16,
    parameter int HEIGHT = 6,
    parameter int LANES  = 4
) (
    input  logic                                       clk,
    input  logic                                       rst,
    input  logic                                       in_valid,
    input  logic [LANES-1:0][DATA_W-1:0]               in_lane,
    output logic [LANES-1:0][2:0][2:0][DATA_W-1:0]     win,
    output logic                                       win_valid
);

    localparam int BEATS = WIDTH / LANES;

    // newest-column taps of every chain, indexed [lane][row lag]
    logic [DATA_W-1:0] tap_new [LANES][WIN_DIM];
    // one-beat-older taps of the two edge chains, indexed [edge][row lag]
    logic [DATA_W-1:0] tap_old [2][WIN_DIM];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        if (kind_of(l, LANES) == CHAIN_EDGE) begin : g_edge
            logic [2*WIN_DIM-1:0][DATA_W-1:0] t;
            rb_chain #(
                .DATA_W(DATA_W),
                .BEATS (BEATS),
                .KIND  (CHAIN_EDGE)
            ) chain_i (
                .clk     (clk),
                .rst     (rst),
                .shift_en(in_valid),
                .din     (in_lane[l]),
                .taps    (t)
            );
            for (genvar k = 0; k < WIN_DIM; k++) begin : g_row
                assign tap_new[l][k]           = t[2*k];
                assign tap_old[l-(LANES-2)][k] = t[2*k+1];
            end
        end else begin : g_mid
            logic [WIN_DIM-1:0][DATA_W-1:0] t;
            rb_chain #(
                .DATA_W(DATA_W),
                .BEATS (BEATS),
                .KIND  (CHAIN_MID)
            ) chain_i (
                .clk     (clk),
                .rst     (rst),
                .shift_en(in_valid),
                .din     (in_lane[l]),
                .taps    (t)
            );
            for (genvar k = 0; k < WIN_DIM; k++) begin : g_row
                assign tap_new[l][k] = t[k];
            end
        end
    end

    // window m, row r, column c: lane offset m+c-2 from the newest beat,
    // negative offsets reach one beat back into the edge chains
    for (genvar m = 0; m < LANES; m++) begin : g_win
        for (genvar r = 0; r < WIN_DIM; r++) begin : g_r
            for (genvar c = 0; c < WIN_DIM; c++) begin : g_c
                localparam int Q   = m + c - 2;
                localparam int LAG = 2 - r;
                if (Q >= 0) begin : g_cur
                    assign win[m][r][c] = tap_new[Q][LAG];
                end else begin : g_prev
                    assign win[m][r][c] = tap_old[Q+2][LAG];
                end
            end
        end
    end

    rb_fill_tracker #(
        .FRAME_BEATS(HEIGHT * BEATS),
        .FILL_BEATS (2 * BEATS + 1)
    ) fill_i (
        .clk      (clk),
        .rst      (rst),
        .accept   (in_valid),
        .win_valid(win_valid)
    );

    // R1
    lane0_lands_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> win[0][2][2] == $past(in_lane[0]));

    // R1
    last_lane_lands_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> win[LANES-1][2][2] == $past(in_lane[LANES-1]));

    // R3
    edge_prev_beat_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid ##1 in_valid |=> win[0][2][0] == $past(in_lane[LANES-2], 2));

    // R4
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(win) && $stable(win_valid)));

endmodule

// File: tb/stencil_reuse_buffer_tb_top.sv
module stencil_reuse_buffer_tb_top;

    localparam int DW    = 8;
    localparam int W     = 12;
    localparam int H     = 5;
    localparam int N     = 4;
    localparam int B     = W / N;
    localparam int FB    = H * B;
    localparam int FILL  = 2 * B + 1;
    localparam int CYCLES = 90;

    logic                          clk = 1'b0;
    logic                          rst;
    logic                          in_valid;
    logic [N-1:0][DW-1:0]          in_lane;
    logic [N-1:0][2:0][2:0][DW-1:0] win;
    logic                          win_valid;

    always #2 clk = ~clk;

    stencil_reuse_buffer #(
        .DATA_W(DW),
        .WIDTH (W),
        .HEIGHT(H),
        .LANES (N)
    ) dut_i (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_lane  (in_lane),
        .win      (win),
        .win_valid(win_valid)
    );

    int n_chk = 0;
    int n_bad = 0;
    int acc   = 0;
    logic                           last_v = 1'b0;
    logic [N-1:0][2:0][2:0][DW-1:0] prev_win;
    logic                           prev_valid;

    function automatic int elem(input int g);
        if (g < 0) return 0;
        return ((g * 29 + 7) % 251) + 1;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // expected windows and valid from the count of accepted beats (R2, R3, R6)
    task automatic check_outputs();
        int x;
        int fb;
        x = (acc - 1) * N;
        for (int m = 0; m < N; m++) begin
            for (int r = 0; r < 3; r++) begin
                for (int c = 0; c < 3; c++) begin
                    int idx;
                    idx = x - W - 1 + m + (r - 1) * W + (c - 1);
                    if (m + c - 2 < 0)
                        chk("R3", $sformatf("win[%0d][%0d][%0d] beat %0d", m, r, c, acc),
                            int'(win[m][r][c]), elem(idx));
                    else
                        chk("R2", $sformatf("win[%0d][%0d][%0d] beat %0d", m, r, c, acc),
                            int'(win[m][r][c]), elem(idx));
                end
            end
        end
        fb = (acc == 0) ? 0 : ((acc - 1) % FB) + 1;
        chk("R6", $sformatf("win_valid beat %0d", acc), int'(win_valid), (fb >= FILL) ? 1 : 0);
        if (last_v) begin
            // R1: newest beat sits at the bottom-right of the outer windows
            chk("R1", "lane0 newest", int'(win[0][2][2]), elem(x));
            chk("R1", "last lane newest", int'(win[N-1][2][2]), elem(x + N - 1));
        end
    endtask

    initial begin : watchdog
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        rst      = 1'b1;
        in_valid = 1'b0;
        in_lane  = '0;
        repeat (3) @(negedge clk);
        // R5: reset state
        for (int m = 0; m < N; m++)
            for (int r = 0; r < 3; r++)
                for (int c = 0; c < 3; c++)
                    chk("R5", $sformatf("reset win[%0d][%0d][%0d]", m, r, c), int'(win[m][r][c]), 0);
        chk("R5", "reset win_valid", int'(win_valid), 0);
        // drive a beat during reset: it must not be taken
        in_valid = 1'b1;
        for (int l = 0; l < N; l++) in_lane[l] = DW'(200 + l);
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        chk("R5", "post-reset corner", int'(win[0][2][2]), 0);
        chk("R5", "post-reset valid", int'(win_valid), 0);

        for (int cyc = 0; cyc < CYCLES; cyc++) begin
            logic v;
            @(negedge clk);
            check_outputs();
            if (!last_v && cyc > 0) begin
                // R4: a stall leaves everything as it was
                chk("R4", "stall window", (win == prev_win) ? 1 : 0, 1);
                chk("R4", "stall valid", int'(win_valid), int'(prev_valid));
            end
            prev_win   = win;
            prev_valid = win_valid;
            v = !((cyc % 4) == 3) && !(cyc >= 20 && cyc < 25);
            in_valid = v;
            for (int l = 0; l < N; l++) in_lane[l] = DW'(elem(acc * N + l));
            if (!v) for (int l = 0; l < N; l++) in_lane[l] = DW'(250 - l);
            @(posedge clk);
            if (v) acc++;
            last_v = v;
        end
        @(negedge clk);
        in_valid = 1'b0;
        check_outputs();
        chk("R6", "frames covered", (acc > 3 * FB) ? 1 : 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule